// File: doc/BRIEF.md
# YCbCr 4:4:4 to 4:2:2 Chroma Subsampler

This block takes a 24-bit YCbCr pixel stream with full chroma on every pixel and turns it into a 16-bit stream. Each output word carries the pixel's luma and a single chroma sample. Active pixels are grouped in pairs counted from the start of each line. The first pixel of a pair carries one chroma component and the second pixel carries the other. Each chroma value is the rounded average of the two samples of that component in the pair. The `CR_CB_N` parameter chooses whether red-difference or blue-difference chroma leads each pair.

The data-enable and sync inputs come out delayed by the same two cycles as the data, so timing at the output lines up with the input. A run-time `bypass` input stops the subsampling and sends the low 16 input bits through untouched. This lets a generated test pattern reach the transmitter exactly as it was written. During blanking the output data is forced to zero.

Input layout is `in_data[23:16]` = Cr, `in_data[15:8]` = Y, `in_data[7:0]` = Cb. Output layout is `out_data[15:8]` = Y, `out_data[7:0]` = chroma.

Top module: `chroma_subsampler`

## Requirements
- R1: `out_de`, `out_hs` and `out_vs` equal `in_de`, `in_hs` and `in_vs` as sampled exactly two clock edges earlier.
- R2: For an active, non-bypassed output word, `out_data[15:8]` is the luma `in_data[15:8]` of the pixel sampled two edges earlier, and `out_data[7:0]` carries a chroma sample.
- R3: Active pixels form pairs counted from the first pixel of a line. With `CR_CB_N`=1 the first pixel of a pair carries Cr (`in_data[23:16]`) and the second carries Cb (`in_data[7:0]`). With `CR_CB_N`=0 the order is reversed.
- R4: The chroma value for each component of a pair is `(a+b+1)>>1`, where a and b are that component's two samples in the pair (rounded half-up).
- R5: Pair counting restarts at every rising edge of `in_de`, so the first pixel of each line is always a first-of-pair pixel.
- R6: If a line has an odd length, its last pixel has no partner. It carries its own unaveraged sample of the leading component.
- R7: When `bypass` is 1 at the edge that loads the output register (one edge after the pixel was sampled), an active `out_data` equals that pixel's `in_data[15:0]`.
- R8: `out_data` is zero whenever `out_de` is 0, including in bypass.
- R9: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass | input | 1 | 1 = pass low input bits through unmodified |
| in_de | input | 1 | Input data enable |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync |
| in_data | input | 24 | Input pixel {Cr, Y, Cb} |
| out_de | output | 1 | Output data enable, two cycles late |
| out_hs | output | 1 | Output horizontal sync, two cycles late |
| out_vs | output | 1 | Output vertical sync, two cycles late |
| out_data | output | 16 | Output word {Y, chroma} |

## Verification
A wrong phase bit shows up as swapped Cb/Cr on the very next active output word. It stays wrong until the next line start, so short and odd-length lines expose it within a few pixels. A stale held chroma value appears on the second pixel of the affected pair, two cycles after that pixel enters. Misaligned sync or enable delay shows at the first transition of the affected signal. Two instances with opposite chroma order are compared each cycle against a behavioural model, so every output word is checked as it appears.

// File: rtl/chroma_subsampler.sv
module chroma_subsampler #(
  parameter bit CR_CB_N = 1'b0,
  parameter int CW      = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bypass,
  input  logic            in_de,
  input  logic            in_hs,
  input  logic            in_vs,
  input  logic [3*CW-1:0] in_data,
  output logic            out_de,
  output logic            out_hs,
  output logic            out_vs,
  output logic [2*CW-1:0] out_data
);

  logic            d_de, d_hs, d_vs, d_ph;
  logic [3*CW-1:0] d_pix;
  logic [CW-1:0]   held;

  function automatic logic [CW-1:0] avg2(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b} + {{CW{1'b0}}, 1'b1};
    return s[CW:1];
  endfunction

  wire [CW-1:0] cb_d = d_pix[CW-1:0];
  wire [CW-1:0] y_d  = d_pix[2*CW-1:CW];
  wire [CW-1:0] cr_d = d_pix[3*CW-1:2*CW];

  wire [CW-1:0] cb_m = in_de ? avg2(cb_d, in_data[CW-1:0])      : cb_d;
  wire [CW-1:0] cr_m = in_de ? avg2(cr_d, in_data[3*CW-1:2*CW]) : cr_d;

  wire [CW-1:0] lead  = CR_CB_N ? cr_m : cb_m;
  wire [CW-1:0] trail = CR_CB_N ? cb_m : cr_m;
  wire [CW-1:0] chroma = d_ph ? held : lead;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_de  <= 1'b0;
      d_hs  <= 1'b0;
      d_vs  <= 1'b0;
      d_ph  <= 1'b0;
      d_pix <= '0;
      held  <= '0;
    end else begin
      d_de  <= in_de;
      d_hs  <= in_hs;
      d_vs  <= in_vs;
      d_pix <= in_data;
      d_ph  <= in_de & d_de & ~d_ph;
      if (d_de && !d_ph) held <= trail;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_de   <= 1'b0;
      out_hs   <= 1'b0;
      out_vs   <= 1'b0;
      out_data <= '0;
    end else begin
      out_de   <= d_de;
      out_hs   <= d_hs;
      out_vs   <= d_vs;
      if (!d_de)       out_data <= '0;
      else if (bypass) out_data <= d_pix[2*CW-1:0];
      else             out_data <= {y_d, chroma};
    end
  end

endmodule

module chroma_subsampler_chk #(
  parameter int CW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bypass,
  input logic            in_de,
  input logic            in_hs,
  input logic            in_vs,
  input logic [2*CW-1:0] in_low,
  input logic            out_de,
  input logic            out_hs,
  input logic            out_vs,
  input logic [2*CW-1:0] out_data
);

  logic [1:0] warm_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_cnt <= 2'd0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end
  wire warm = (warm_cnt == 2'd3);

  // R1
  de_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> out_de == $past(in_de, 2));

  // R1
  hs_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> out_hs == $past(in_hs, 2));

  // R1
  vs_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> out_vs == $past(in_vs, 2));

  // R8
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_de |-> out_data == '0);

  // R7
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_de && $past(bypass)) |-> out_data == $past(in_low, 2));

  // R2
  luma_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_de && !$past(bypass)) |-> out_data[2*CW-1:CW] == $past(in_low[2*CW-1:CW], 2));

  // R9
  always @(posedge clk) begin
    if (!rst_n) reset_zero_chk: assert (out_data == '0 && !out_de && !out_hs && !out_vs);
  end

endmodule

bind chroma_subsampler chroma_subsampler_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bypass(bypass), .in_de(in_de), .in_hs(in_hs),
  .in_vs(in_vs), .in_low(in_data[2*CW-1:0]), .out_de(out_de), .out_hs(out_hs),
  .out_vs(out_vs), .out_data(out_data)
);

// File: tb/tb_chroma_subsampler.sv
`timescale 1ns/1ps
module tb_chroma_subsampler;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bypass = 1'b0;
  logic        in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
  logic [23:0] in_data = '0;
  logic        a_de, a_hs, a_vs, b_de, b_hs, b_vs;
  logic [15:0] a_data, b_data;

  always #4 clk = ~clk;

  chroma_subsampler #(.CR_CB_N(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .in_de(in_de), .in_hs(in_hs),
    .in_vs(in_vs), .in_data(in_data), .out_de(a_de), .out_hs(a_hs),
    .out_vs(a_vs), .out_data(a_data));

  chroma_subsampler #(.CR_CB_N(1'b1)) dut_cr (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .in_de(in_de), .in_hs(in_hs),
    .in_vs(in_vs), .in_data(in_data), .out_de(b_de), .out_hs(b_hs),
    .out_vs(b_vs), .out_data(b_data));

  localparam int HN = 8192;
  logic [23:0] h_pix [HN];
  bit          h_de [HN], h_hs [HN], h_vs [HN], h_by [HN], h_ph [HN], h_rst [HN];
  int n = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  function automatic logic [7:0] comp(input logic [23:0] x, input bit red);
    return red ? x[23:16] : x[7:0];
  endfunction

  task automatic check_dut(input bit cr, input logic ode, input logic ohs,
                           input logic ovs, input logic [15:0] od);
    int p;
    int q;
    bit red;
    logic [8:0] s;
    logic [15:0] exp_d;
    string tag;
    p = n - 2;
    if (p < 0) return;
    checks++;
    if (!rst_n) begin
      if (ode !== 1'b0 || ohs !== 1'b0 || ovs !== 1'b0 || od !== 16'h0) begin
        fails++;
        $display("FAIL R9 reset cr=%0d: got de=%b hs=%b vs=%b data=%h, expected all zero",
                 cr, ode, ohs, ovs, od);
      end
      return;
    end
    if (ode !== h_de[p] || ohs !== h_hs[p] || ovs !== h_vs[p]) begin
      fails++;
      $display("FAIL R1 cr=%0d idx=%0d: got de/hs/vs=%b%b%b, expected %b%b%b",
               cr, p, ode, ohs, ovs, h_de[p], h_hs[p], h_vs[p]);
    end
    checks++;
    if (!h_de[p]) begin
      exp_d = 16'h0; tag = "R8";
    end else if (h_by[n-1]) begin
      exp_d = h_pix[p][15:0]; tag = "R7";
    end else begin
      if (!h_ph[p]) begin
        red = cr;
        q = h_de[p+1] ? p + 1 : p;
        tag = (q == p) ? "R6" : ((p == 0 || !h_de[p-1]) ? "R5" : "R3");
      end else begin
        red = !cr;
        q = p - 1;
        tag = "R4";
      end
      s = {1'b0, comp(h_pix[p], red)} + {1'b0, comp(h_pix[q], red)} + 9'd1;
      exp_d = {h_pix[p][15:8], s[8:1]};
      if (od[15:8] !== exp_d[15:8]) tag = "R2";
    end
    if (od !== exp_d) begin
      fails++;
      $display("FAIL %s cr=%0d idx=%0d: got data=%h, expected %h", tag, cr, p, od, exp_d);
    end
  endtask

  task automatic step(input bit de, input bit hs, input bit vs,
                      input logic [23:0] d, input bit by);
    @(negedge clk);
    check_dut(1'b0, a_de, a_hs, a_vs, a_data);
    check_dut(1'b1, b_de, b_hs, b_vs, b_data);
    in_de = de; in_hs = hs; in_vs = vs; in_data = d; bypass = by;
    h_de[n] = de; h_hs[n] = hs; h_vs[n] = vs; h_pix[n] = d; h_by[n] = by;
    h_rst[n] = !rst_n;
    h_ph[n] = (n > 0 && de && h_de[n-1]) ? !h_ph[n-1] : 1'b0;
    n++;
  endtask

  task automatic line(input int len, input bit vs, input int bymode);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, vs, $urandom, $urandom_range(0, 1));
    for (int i = 0; i < 2; i++) step(1'b0, 1'b0, vs, $urandom, 1'b0);
    for (int i = 0; i < len; i++)
      step(1'b1, 1'b0, vs, $urandom,
           bymode == 2 ? 1'($urandom_range(0, 1)) : 1'(bymode));
    for (int i = 0; i < 2; i++) step(1'b0, 1'b0, vs, $urandom, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    // R1 R8: blanking with vertical sync
    line(0, 1'b1, 0);
    // R3 R4 R5: even lines; R6: odd lines; R2 luma throughout
    line(8, 1'b1, 0);
    line(7, 1'b0, 0);
    line(1, 1'b0, 0);
    line(2, 1'b0, 0);
    line(5, 1'b0, 0);
    // boundary values for rounding
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 24'hFF00FF, 1'b0);
    step(1'b1, 1'b0, 1'b0, 24'hFEFFFE, 1'b0);
    step(1'b1, 1'b0, 1'b0, 24'h010000, 1'b0);
    step(1'b1, 1'b0, 1'b0, 24'h000001, 1'b0);
    // back-to-back lines with a single blank cycle restart phase (R5)
    step(1'b0, 1'b0, 1'b0, 24'h123456, 1'b0);
    step(1'b1, 1'b0, 1'b0, 24'hA0B0C0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 24'h102030, 1'b0);
    step(1'b1, 1'b0, 1'b0, 24'h405060, 1'b0);
    step(1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
    // R7: bypass lines, constant and toggling
    line(9, 1'b0, 1);
    line(16, 1'b0, 2);
    line(6, 1'b1, 2);
    for (int k = 0; k < 40; k++) line(2 + (k % 13), k % 7 == 0, k % 3);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
    // R9: reset in the middle of an active line
    step(1'b1, 1'b0, 1'b0, 24'h777777, 1'b0);
    step(1'b1, 1'b1, 1'b1, 24'h888888, 1'b0);
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    line(4, 1'b0, 0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected end of stimulus");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule